// File: doc/BRIEF.md
# Memory Protection Access Gate

The gate sits between a CPU-style access port and two memories: a program EPROM array and a 256-byte register file. Each request carries a kind, an address and write data. The gate either forwards the request as a memory strobe or refuses it. A refused read returns a neutral byte. A refused write is dropped. Each refusal raises a violation pulse for one cycle.

Two lock flags decide which requests are refused.

- **ROM lock.** Once armed, every EPROM read, verify and program access is refused.
- **RAM lock.** Once armed, accesses to offsets 128..239 of the register file are refused. Offsets 240..255 hold the mode and configuration registers and stay open. The lower half of the register file also stays open.

Both flags are sticky. Neither the functional reset `rstN` nor any command clears them. Only the power-on input `porN` clears them, which models non-volatile storage.

The command that arms the RAM lock is accepted only when bit 6 of the interrupt-mask value is already 1. The command that arms the ROM lock is accepted only while `rstN` is high.

The memories are outside the block. They sample the strobes and address on a rising edge, and a memory read returns its byte in the following cycle.

Top module: `memProtectGate`

## Requirements
- R1: A register access at offsets 0..127 is never refused. The strobe `regRd` or `regWr` is asserted combinationally in the request cycle, and read data appears on `rdData` with `rdValid` high in the next cycle.
- R2: While the ROM lock is set, kinds 2, 3 and 4 assert none of `romRd`, `romVfy` or `romPgm`, and they are treated as refused.
- R3: While the RAM lock is set, register reads and writes at offsets 128..239 assert neither `regRd` nor `regWr`, and they are treated as refused.
- R4: While the RAM lock is set, offsets 240..255 are still forwarded exactly as when unlocked.
- R5: A RAM-lock command takes effect only when `imrValue` bit 6 is 1 in the command cycle. Otherwise the command is ignored.
- R6: A ROM-lock command given while `rstN` is low is rejected. With `rstN` high, the command is accepted.
- R7: Once set, a lock flag stays set through `rstN` pulses and later commands. Only `porN` low clears it.
- R8: A refused read yields `rdData` = 0xFF with `rdValid` high in the next cycle. A refused write never reaches the memory. Each refused request raises `violation` in the next cycle, for that cycle only.
- R9: While `rstN` is low, no memory strobe is asserted, and in the next cycle `rdValid` and `violation` are low.
- R10: After `porN` goes high, both locks are clear, all strobes are low, and `rdValid`, `rdData` and `violation` are 0.
- R11: The `reqKind` encoding is as follows.
  - 0: register read.
  - 1: register write.
  - 2: ROM read, which asserts `romRd`.
  - 3: ROM verify, which asserts `romRd` and `romVfy`.
  - 4: ROM program, which asserts `romPgm`.
  - Codes 5..7 do nothing.
- R12: A lock command changes the gating of requests from the cycle after the command onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on initialisation, active low, asynchronous; the only way to clear the locks |
| rstN | input | 1 | Functional reset, active low, synchronous; does not clear the locks |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 3 | Access kind (see R11) |
| reqAddr | input | 14 | EPROM address; bits 7:0 give the register offset |
| reqWdata | input | 8 | Write or program data |
| setRomLock | input | 1 | Command to set the ROM lock |
| setRamLock | input | 1 | Command to set the RAM lock |
| imrValue | input | 8 | Current interrupt-mask register value |
| romRdata | input | 8 | EPROM read data, one cycle after `romRd` |
| regRdata | input | 8 | Register file read data, one cycle after `regRd` |
| romRd | output | 1 | EPROM read strobe |
| romVfy | output | 1 | EPROM verify qualifier |
| romPgm | output | 1 | EPROM program strobe |
| romAddr | output | 14 | EPROM address |
| regRd | output | 1 | Register file read strobe |
| regWr | output | 1 | Register file write strobe |
| regAddr | output | 8 | Register file offset |
| memWdata | output | 8 | Write or program data to the memories |
| rdValid | output | 1 | Read result valid |
| rdData | output | 8 | Read result |
| violation | output | 1 | One-cycle pulse for each refused request |

## Verification
The bench sweeps all 256 register offsets before and after the RAM lock is set. This targets the window edges at 127/128 and 239/240. A design with an off-by-one window would lock out a configuration register or leave offset 239 open.

Offsets 128..239 are written while the lock is set and then read back after a power-on cycle. This exposes a design that drops only the violation but still writes the memory.

Each lock command is also issued while its precondition is false: interrupt-mask bit 6 clear for the RAM lock, and `rstN` low for the ROM lock. A design that ignores the precondition would lock early and refuse accesses that must pass.

Finally, `rstN` is pulsed after the locks are set. A design that clears the flags on functional reset would reopen the protected regions.

// File: rtl/memGatePkg.sv
package memGatePkg;

  typedef enum logic [2:0] {
    K_REG_RD  = 3'd0,
    K_REG_WR  = 3'd1,
    K_ROM_RD  = 3'd2,
    K_ROM_VFY = 3'd3,
    K_ROM_PGM = 3'd4
  } reqKind_e;

  typedef struct packed {
    logic regRd;
    logic regWr;
    logic romRd;
    logic romVfy;
    logic romPgm;
    logic readDenied;
    logic deny;
  } gateStrobes_t;

endpackage

// File: rtl/gateCtrl.sv
module gateCtrl
  import memGatePkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int DATA_W      = 8,
  parameter int PROT_LO     = 128,
  parameter int PROT_HI     = 239,
  parameter int IMR_ARM_BIT = 6
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [REG_AW-1:0] regOff,
  input  logic              setRomLock,
  input  logic              setRamLock,
  input  logic [DATA_W-1:0] imrValue,
  output gateStrobes_t      strobes,
  output logic              romLocked,
  output logic              ramLocked
);

  localparam logic [REG_AW-1:0] LO_V = REG_AW'(PROT_LO);
  localparam logic [REG_AW-1:0] HI_V = REG_AW'(PROT_HI);

  logic imrArm;
  logic unusedImrBits;
  assign imrArm        = imrValue[IMR_ARM_BIT];
  assign unusedImrBits = ^imrValue;

  // Lock flags: cleared only by power-on, never by the functional reset.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      romLocked <= 1'b0;
      ramLocked <= 1'b0;
    end else begin
      if (setRomLock && rstN) romLocked <= 1'b1;
      if (setRamLock && imrArm) ramLocked <= 1'b1;
    end
  end

  logic live, inWindow, isRegRd, isRegWr, isRomRd, isRomVfy, isRomPgm;
  logic isReg, isRom, regDeny, romDeny, denyNow;

  always_comb begin
    live     = reqValid && rstN;
    inWindow = (regOff >= LO_V) && (regOff <= HI_V);
    isRegRd  = reqKind == K_REG_RD;
    isRegWr  = reqKind == K_REG_WR;
    isRomRd  = reqKind == K_ROM_RD;
    isRomVfy = reqKind == K_ROM_VFY;
    isRomPgm = reqKind == K_ROM_PGM;
    isReg    = isRegRd || isRegWr;
    isRom    = isRomRd || isRomVfy || isRomPgm;
    regDeny  = ramLocked && inWindow;
    romDeny  = romLocked;
    denyNow  = live && ((isReg && regDeny) || (isRom && romDeny));

    strobes.regRd      = live && isRegRd && !regDeny;
    strobes.regWr      = live && isRegWr && !regDeny;
    strobes.romRd      = live && (isRomRd || isRomVfy) && !romDeny;
    strobes.romVfy     = live && isRomVfy && !romDeny;
    strobes.romPgm     = live && isRomPgm && !romDeny;
    strobes.deny       = denyNow;
    strobes.readDenied = denyNow && (isRegRd || isRomRd || isRomVfy);
  end

endmodule

// File: rtl/gateDatapath.sv
module gateDatapath
  import memGatePkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int REG_AW = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] romRdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              romRd,
  output logic              romVfy,
  output logic              romPgm,
  output logic [ADDR_W-1:0] romAddr,
  output logic              regRd,
  output logic              regWr,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              violation
);

  logic rdPend, rdMask, rdFromRom;

  assign romRd    = strobes.romRd;
  assign romVfy   = strobes.romVfy;
  assign romPgm   = strobes.romPgm;
  assign regRd    = strobes.regRd;
  assign regWr    = strobes.regWr;
  assign romAddr  = reqAddr;
  assign regAddr  = reqAddr[REG_AW-1:0];
  assign memWdata = reqWdata;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rdPend    <= 1'b0;
      rdMask    <= 1'b0;
      rdFromRom <= 1'b0;
      violation <= 1'b0;
    end else if (!rstN) begin
      rdPend    <= 1'b0;
      rdMask    <= 1'b0;
      rdFromRom <= 1'b0;
      violation <= 1'b0;
    end else begin
      rdPend    <= strobes.regRd || strobes.romRd || strobes.readDenied;
      rdMask    <= strobes.readDenied;
      rdFromRom <= strobes.romRd;
      violation <= strobes.deny;
    end
  end

  always_comb begin
    rdValid = rdPend;
    if (!rdPend)        rdData = '0;
    else if (rdMask)    rdData = '1;
    else if (rdFromRom) rdData = romRdata;
    else                rdData = regRdata;
  end

endmodule

// File: rtl/memProtectGate.sv
module memProtectGate
  import memGatePkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int REG_AW      = 8,
  parameter int DATA_W      = 8,
  parameter int PROT_LO     = 128,
  parameter int PROT_HI     = 239,
  parameter int IMR_ARM_BIT = 6
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              setRomLock,
  input  logic              setRamLock,
  input  logic [DATA_W-1:0] imrValue,
  input  logic [DATA_W-1:0] romRdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              romRd,
  output logic              romVfy,
  output logic              romPgm,
  output logic [ADDR_W-1:0] romAddr,
  output logic              regRd,
  output logic              regWr,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              violation
);

  gateStrobes_t strobes;
  logic romLocked, ramLocked;

  gateCtrl #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .PROT_LO(PROT_LO),
    .PROT_HI(PROT_HI), .IMR_ARM_BIT(IMR_ARM_BIT)
  ) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .reqValid(reqValid),
    .reqKind(reqKind), .regOff(reqAddr[REG_AW-1:0]),
    .setRomLock(setRomLock), .setRamLock(setRamLock), .imrValue(imrValue),
    .strobes(strobes), .romLocked(romLocked), .ramLocked(ramLocked)
  );

  gateDatapath #(
    .ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .porN(porN), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .romRdata(romRdata), .regRdata(regRdata),
    .romRd(romRd), .romVfy(romVfy), .romPgm(romPgm), .romAddr(romAddr),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .memWdata(memWdata),
    .rdValid(rdValid), .rdData(rdData), .violation(violation)
  );

endmodule

// File: rtl/memProtectGateChecker.sv
module memProtectGateChecker #(
  parameter int REG_AW  = 8,
  parameter int PROT_LO = 128,
  parameter int PROT_HI = 239
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqKind,
  input logic [REG_AW-1:0] regAddr,
  input logic              romRd,
  input logic              romVfy,
  input logic              romPgm,
  input logic              regRd,
  input logic              regWr,
  input logic              rdValid,
  input logic              violation,
  input logic              romLocked,
  input logic              ramLocked
);

  logic inWin, cfgReg;
  assign inWin  = (int'(regAddr) >= PROT_LO) && (int'(regAddr) <= PROT_HI);
  assign cfgReg = int'(regAddr) > PROT_HI;

  a_r1_lower_passes: assert property (@(posedge clk) disable iff (!porN)
    (reqValid && rstN && reqKind == 3'd0 && int'(regAddr) < PROT_LO) |-> regRd);

  a_r2_rom_locked_quiet: assert property (@(posedge clk) disable iff (!porN)
    romLocked |-> !(romRd || romVfy || romPgm));

  a_r3_window_quiet: assert property (@(posedge clk) disable iff (!porN)
    (ramLocked && inWin) |-> !(regRd || regWr));

  a_r4_cfg_open: assert property (@(posedge clk) disable iff (!porN)
    (reqValid && rstN && reqKind == 3'd1 && cfgReg) |-> regWr);

  a_r6_rom_reject_in_reset: assert property (@(posedge clk) disable iff (!porN)
    (!rstN && !romLocked) |=> !romLocked);

  a_r7_rom_sticky: assert property (@(posedge clk) disable iff (!porN)
    romLocked |=> romLocked);

  a_r7_ram_sticky: assert property (@(posedge clk) disable iff (!porN)
    ramLocked |=> ramLocked);

  a_r8_violation_cause: assert property (@(posedge clk) disable iff (!porN)
    violation |-> $past(reqValid && rstN));

  a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!porN)
    !rstN |-> !(regRd || regWr || romRd || romPgm));

  a_r9_no_result_after_reset: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> !(rdValid || violation));

  a_r11_vfy_implies_rd: assert property (@(posedge clk) disable iff (!porN)
    romVfy |-> romRd);

endmodule

bind memProtectGate memProtectGateChecker #(
  .REG_AW(REG_AW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
) chk_i (
  .clk(clk), .porN(porN), .rstN(rstN), .reqValid(reqValid),
  .reqKind(reqKind), .regAddr(regAddr), .romRd(romRd), .romVfy(romVfy),
  .romPgm(romPgm), .regRd(regRd), .regWr(regWr), .rdValid(rdValid),
  .violation(violation), .romLocked(romLocked), .ramLocked(ramLocked)
);

// File: tb/memProtectGate_tb.sv
module memProtectGate_tb_top;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [13:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        setRomLock = 1'b0;
  logic        setRamLock = 1'b0;
  logic [7:0]  imrValue = '0;
  logic [7:0]  romRdata = '0;
  logic [7:0]  regRdata = '0;
  logic        romRd, romVfy, romPgm, regRd, regWr, rdValid, violation;
  logic [13:0] romAddr;
  logic [7:0]  regAddr, memWdata, rdData;

  int nTests = 0;
  int nFails = 0;
  logic [7:0] regMem [256];
  logic [7:0] expMem [256];
  bit expRomLk = 0;
  bit expRamLk = 0;

  always #4 clk = ~clk;

  memProtectGate dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .setRomLock(setRomLock), .setRamLock(setRamLock), .imrValue(imrValue),
    .romRdata(romRdata), .regRdata(regRdata),
    .romRd(romRd), .romVfy(romVfy), .romPgm(romPgm), .romAddr(romAddr),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .memWdata(memWdata),
    .rdValid(rdValid), .rdData(rdData), .violation(violation)
  );

  function automatic logic [7:0] romByte(input logic [13:0] a);
    return 8'((a * 7) + (a >> 8) + 3);
  endfunction

  // Memory models: data one cycle after the strobe.
  always @(posedge clk) begin
    if (regWr) regMem[regAddr] <= memWdata;
    if (regRd) regRdata <= regMem[regAddr];
    if (romRd) romRdata <= romByte(romAddr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one request, check strobes in its cycle and the result in the next.
  task automatic access(input string req, input logic [2:0] kind,
                        input logic [13:0] addr, input logic [7:0] wd);
    logic [7:0] off;
    bit isReg, isRom, denied, isRead;
    logic [4:0] expStb;
    logic [7:0] expRd;
    off    = addr[7:0];
    isReg  = kind <= 3'd1;
    isRom  = kind >= 3'd2 && kind <= 3'd4;
    denied = rstN && ((isReg && expRamLk && off >= 8'd128 && off <= 8'd239) ||
                      (isRom && expRomLk));
    isRead = kind == 3'd0 || kind == 3'd2 || kind == 3'd3;
    expStb = '0;
    if (rstN && !denied) begin
      expStb[4] = kind == 3'd2 || kind == 3'd3;
      expStb[3] = kind == 3'd3;
      expStb[2] = kind == 3'd4;
      expStb[1] = kind == 3'd0;
      expStb[0] = kind == 3'd1;
    end
    if (denied)             expRd = 8'hFF;
    else if (kind == 3'd0)  expRd = expMem[off];
    else                    expRd = romByte(addr);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqWdata = wd;
    #1;
    chk({req, " strobes"}, 32'({romRd, romVfy, romPgm, regRd, regWr}), 32'(expStb));
    @(negedge clk);
    reqValid = 1'b0;
    if (rstN && !denied && kind == 3'd1) expMem[off] = wd;
    chk({req, " rdValid"}, 32'(rdValid), 32'(rstN && isRead && (isReg || isRom)));
    if (rstN && isRead) chk({req, " rdData"}, 32'(rdData), 32'(expRd));
    chk({req, " violation"}, 32'(violation), 32'(denied));
  endtask

  task automatic lockCmd(input bit rom, input bit ram);
    @(negedge clk);
    setRomLock = rom; setRamLock = ram;
    @(negedge clk);
    setRomLock = 1'b0; setRamLock = 1'b0;
  endtask

  task automatic powerOn();
    @(negedge clk);
    porN = 1'b0; rstN = 1'b0;
    expRomLk = 0; expRamLk = 0;
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin regMem[i] = 8'h00; expMem[i] = 8'h00; end
    powerOn();
    // R10: idle after power-on
    #1;
    chk("R10 idle strobes", 32'({romRd, romPgm, regRd, regWr}), 32'd0);
    chk("R10 idle result", 32'({rdValid, rdData, violation}), 32'd0);

    // R1 / R4: fill and read back all offsets unlocked
    for (int a = 0; a < 256; a++) access("R1 fill", 3'd1, 14'(a), 8'(a ^ 8'h5A));
    for (int a = 0; a < 256; a++) access("R1 readback", 3'd0, 14'(a), 8'h00);

    // R11: ROM kinds and unused codes
    for (int a = 0; a < 64; a++) access("R11 rom read", 3'd2, 14'(a * 251), 8'h00);
    access("R11 rom verify", 3'd3, 14'h1234, 8'h00);
    access("R11 rom program", 3'd4, 14'h0F0F, 8'hA5);
    for (int k = 5; k < 8; k++) access("R11 unused code", 3'(k), 14'h0010, 8'h00);

    // R9: no strobes while functional reset is low
    @(negedge clk); rstN = 1'b0;
    access("R9 read in reset", 3'd0, 14'h0005, 8'h00);
    access("R9 rom in reset", 3'd2, 14'h0005, 8'h00);

    // R6: ROM lock while reset low is rejected
    lockCmd(1'b1, 1'b0);
    @(negedge clk); rstN = 1'b1;
    access("R6 rom open after rejected cmd", 3'd2, 14'h0123, 8'h00);

    // R5: RAM lock without mask bit 6 ignored
    imrValue = 8'hBF;
    lockCmd(1'b0, 1'b1);
    access("R5 window open after ignored cmd", 3'd0, 14'd200, 8'h00);

    // R5 / R12: arm the RAM lock
    imrValue = 8'h40;
    @(negedge clk);
    setRamLock = 1'b1;
    expRamLk = 1;
    access("R12 window shut next cycle", 3'd0, 14'd128, 8'h00);
    setRamLock = 1'b0;
    imrValue = 8'h00;

    // R3 / R4 / R8: sweep with lock set, writes then reads
    for (int a = 0; a < 256; a++) access("R3 R4 R8 locked write", 3'd1, 14'(a), 8'(~a));
    for (int a = 0; a < 256; a++) access("R3 R4 R8 locked read", 3'd0, 14'(a), 8'h00);

    // R2 / R6: ROM lock with reset high
    lockCmd(1'b1, 1'b0);
    expRomLk = 1;
    access("R2 rom read blocked", 3'd2, 14'h0040, 8'h00);
    access("R2 rom verify blocked", 3'd3, 14'h0041, 8'h00);
    access("R2 rom program blocked", 3'd4, 14'h0042, 8'h11);

    // R7: locks survive functional reset
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    access("R7 rom still locked", 3'd2, 14'h0040, 8'h00);
    access("R7 ram still locked", 3'd0, 14'd239, 8'h00);
    access("R7 cfg still open", 3'd0, 14'd240, 8'h00);

    // R8 / R10: after power-on, discarded writes left memory unchanged
    powerOn();
    for (int a = 120; a < 248; a++) access("R8 discarded writes", 3'd0, 14'(a), 8'h00);
    access("R10 rom open after power-on", 3'd2, 14'h0040, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule